// File: doc/BRIEF.md
# Serial Peripheral Master with Frame Hold

This block is a serial peripheral (SPI) master for a single slave in mode 0. A host loads one transmit word at a time through a small register-style port: the word value, its character length (1 to 16 bits) and a hold flag. Loading a word starts the transfer. The block drives chip select low and waits a setup half period. It then shifts the word out MSB first on MOSI while it samples MISO into a receive shift register.

When the word is done, the received bits go into a right-aligned receive buffer and a ready flag is set. A read strobe clears the flag. The hold flag decides whether chip select goes high after the word or stays low. Keeping it low lets the host chain several short words into one long frame, such as an opcode followed by an address and data.

The serial clock runs only while a loaded word is being shifted. To read from a slave, the host therefore sends dummy words, and each of them clocks back the same number of bits. The serial clock half period is a programmable number of system clocks.

Top module: `spiHoldMaster`

## Requirements
- R1: After reset, csN is 1, sclk is 0, busy is 0 and rxReady is 0.
- R2: A write with wrLen = n produces exactly n+1 sclk pulses. The low n+1 bits of wrData appear on mosi MSB first, that is, bit n first.
- R3: With wrHold = 0, csN is 1 once busy has dropped at the end of the word.
- R4: With wrHold = 1, csN stays 0 after the word. A following word continues the same frame, and csN does not change while busy.
- R5: sclk is 0 whenever no word is being shifted. It pulses only while csN is 0, and no pulses occur without a write.
- R6: mosi changes only on sclk falling edges (or at the load). miso is sampled on each sclk rising edge, and the first bit received becomes the MSB of the received value.
- R7: At the end of each word, rxData holds the received bits right-aligned (bits above the length are 0) and rxReady becomes 1. A pulse on rdEn clears rxReady.
- R8: busy is 1 from the accepted write until the word ends. A write while busy is ignored and has no effect on mosi, the pulse count or later activity.
- R9: Each sclk high and low phase lasts divHalf system clocks. A divHalf of 0 acts as 1.
- R10: After every accepted write, sclk stays low for exactly one half period, with csN low, before its first rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| divHalf | input | DIV_W | Serial clock half period in system clocks (0 acts as 1) |
| wrEn | input | 1 | Load a transmit word (ignored while busy) |
| wrData | input | DATA_W | Transmit word, right-aligned |
| wrLen | input | LEN_W | Character length minus one |
| wrHold | input | 1 | Keep chip select low after this word |
| rdEn | input | 1 | Read strobe, clears rxReady |
| rxData | output | DATA_W | Last received word, right-aligned |
| rxReady | output | 1 | Receive buffer holds an unread word |
| busy | output | 1 | A word is shifting |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |
| csN | output | 1 | Active-low chip select |

## Verification
The bench models a slave that streams a fixed 64-bit pattern, restarting it at each chip-select fall. This exposes a receive path that loses its position across held words, because the expected bits of a chained frame would then come out shifted. The bench counts serial clock pulses and high-phase cycles per word, so a design that emits an extra clock, mishandles lengths 1 or 16, or treats a zero divider as something other than one gives the wrong counts. It also chains a 40-bit frame of held words, to catch chip select being released early. Finally, it loads a second word mid-transfer: a design that accepts it would corrupt the shifted bits or start an unasked-for transfer.

// File: rtl/spiHoldPkg.sv
package spiHoldPkg;

  // Strobes from the sequencer to the shifting datapath, one cycle wide.
  typedef struct packed {
    logic load;    // accept a word, pull chip select low
    logic rise;    // serial clock goes high, sample miso
    logic fall;    // serial clock goes low, advance transmit bit
    logic finish;  // last falling edge of the word
  } spiStrobeT;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2
  } spiStateT;

endpackage

// File: rtl/spiHoldCtrl.sv
module spiHoldCtrl
  import spiHoldPkg::*;
#(
  parameter int LEN_W = 4,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [LEN_W-1:0] wrLen,
  input  logic [DIV_W-1:0] divHalf,
  output spiStrobeT        strb,
  output logic             busy
);

  localparam int CNT_W = LEN_W + 1;

  spiStateT         state;
  logic [DIV_W-1:0] halfLat;
  logic [DIV_W-1:0] phaseCnt;
  logic [CNT_W-1:0] bitsLeft;
  logic             lastTick;
  logic [DIV_W-1:0] halfEff;

  assign halfEff  = (divHalf == '0) ? DIV_W'(1) : divHalf;
  assign lastTick = (phaseCnt == halfLat - DIV_W'(1));
  assign busy     = (state != ST_IDLE);

  always_comb begin
    strb = '0;
    unique case (state)
      ST_IDLE: strb.load = wrEn;
      ST_LOW:  strb.rise = lastTick;
      ST_HIGH: begin
        if (lastTick) begin
          if (bitsLeft == CNT_W'(1)) strb.finish = 1'b1;
          else                       strb.fall   = 1'b1;
        end
      end
      default: strb = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      halfLat  <= DIV_W'(1);
      phaseCnt <= '0;
      bitsLeft <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (wrEn) begin
            state    <= ST_LOW;
            halfLat  <= halfEff;
            phaseCnt <= '0;
            bitsLeft <= CNT_W'(wrLen) + CNT_W'(1);
          end
        end
        ST_LOW: begin
          if (lastTick) begin
            state    <= ST_HIGH;
            phaseCnt <= '0;
          end else begin
            phaseCnt <= phaseCnt + DIV_W'(1);
          end
        end
        ST_HIGH: begin
          if (lastTick) begin
            phaseCnt <= '0;
            bitsLeft <= bitsLeft - CNT_W'(1);
            state    <= (bitsLeft == CNT_W'(1)) ? ST_IDLE : ST_LOW;
          end else begin
            phaseCnt <= phaseCnt + DIV_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R9
  phase_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (phaseCnt < halfLat));

  // R2
  bits_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (bitsLeft != '0));

endmodule

// File: rtl/spiHoldData.sv
module spiHoldData
  import spiHoldPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  spiStrobeT         strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [LEN_W-1:0]  wrLen,
  input  logic              wrHold,
  input  logic              rdEn,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic              csN,
  output logic [DATA_W-1:0] rxData,
  output logic              rxReady
);

  localparam int SH_W = $clog2(DATA_W) + 1;

  logic [DATA_W-1:0] txShift;
  logic [DATA_W-1:0] rxShift;
  logic              holdLat;
  logic [SH_W-1:0]   alignShift;

  assign alignShift = SH_W'(DATA_W - 1) - SH_W'(wrLen);
  assign mosi       = txShift[DATA_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      holdLat <= 1'b0;
      sclk    <= 1'b0;
      csN     <= 1'b1;
    end else begin
      if (strb.load) begin
        txShift <= wrData << alignShift;
        rxShift <= '0;
        holdLat <= wrHold;
        csN     <= 1'b0;
      end
      if (strb.rise) begin
        sclk    <= 1'b1;
        rxShift <= {rxShift[DATA_W-2:0], miso};
      end
      if (strb.fall) begin
        sclk    <= 1'b0;
        txShift <= {txShift[DATA_W-2:0], 1'b0};
      end
      if (strb.finish) begin
        sclk <= 1'b0;
        csN  <= !holdLat;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData  <= '0;
      rxReady <= 1'b0;
    end else if (strb.finish) begin
      rxData  <= rxShift;
      rxReady <= 1'b1;
    end else if (rdEn) begin
      rxReady <= 1'b0;
    end
  end

  // R7
  ready_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !strb.finish) |=> !rxReady);

  // R6
  sample_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.rise |=> sclk);

endmodule

// File: rtl/spiHoldMaster.sv
module spiHoldMaster
  import spiHoldPkg::*;
#(
  parameter int  DATA_W = 16,
  parameter int  DIV_W  = 8,
  localparam int LEN_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DIV_W-1:0]  divHalf,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic [LEN_W-1:0]  wrLen,
  input  logic              wrHold,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rxData,
  output logic              rxReady,
  output logic              busy,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              csN
);

  spiStrobeT strb;

  spiHoldCtrl #(.LEN_W(LEN_W), .DIV_W(DIV_W)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrLen   (wrLen),
    .divHalf (divHalf),
    .strb    (strb),
    .busy    (busy)
  );

  spiHoldData #(.DATA_W(DATA_W), .LEN_W(LEN_W)) uData (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wrData  (wrData),
    .wrLen   (wrLen),
    .wrHold  (wrHold),
    .rdEn    (rdEn),
    .miso    (miso),
    .sclk    (sclk),
    .mosi    (mosi),
    .csN     (csN),
    .rxData  (rxData),
    .rxReady (rxReady)
  );

  // R5
  sclk_in_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    sclk |-> (!csN && busy));

  // R6
  mosi_steady_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclk) |-> $stable(mosi));

  // R4
  cs_steady_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(csN));

  // R7
  ready_at_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxReady) |-> ($past(busy) && !busy));

endmodule

// File: tb/sim_spiHoldMaster.sv
module sim_spiHoldMaster;

  localparam int DATA_W = 16;
  localparam int DIV_W  = 8;
  localparam logic [63:0] RESP = 64'hA5C3_0F96_1E7B_D248;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [DIV_W-1:0]  divHalf = '0;
  logic              wrEn = 1'b0;
  logic [DATA_W-1:0] wrData = '0;
  logic [3:0]        wrLen = '0;
  logic              wrHold = 1'b0;
  logic              rdEn = 1'b0;
  logic [DATA_W-1:0] rxData;
  logic              rxReady, busy, sclk, mosi, csN;
  logic              miso = 1'b0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int rises = 0;
  int hiCyc = 0;
  int leadCyc = 0;
  int sIdx = 0;
  int predPos = 0;
  logic [31:0] capt = '0;

  always #4 clk = ~clk;

  spiHoldMaster #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u0 (
    .clk(clk), .rstN(rstN), .divHalf(divHalf), .wrEn(wrEn), .wrData(wrData),
    .wrLen(wrLen), .wrHold(wrHold), .rdEn(rdEn), .rxData(rxData),
    .rxReady(rxReady), .busy(busy), .sclk(sclk), .mosi(mosi), .miso(miso),
    .csN(csN)
  );

  // Slave model: streams RESP MSB first, restarting at each frame start.
  always @(negedge csN) begin
    sIdx = 0;
    miso = RESP[63];
  end
  always @(negedge sclk) begin
    if (!csN) begin
      sIdx = sIdx + 1;
      miso = RESP[63 - (sIdx % 64)];
    end
  end
  always @(posedge sclk) begin
    rises = rises + 1;
    capt  = {capt[30:0], mosi};
  end
  always @(negedge clk) begin
    cycles = cycles + 1;
    if (sclk) hiCyc = hiCyc + 1;
    if (busy && !sclk && rises == 0) leadCyc = leadCyc + 1;
  end

  task automatic check(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int expRx(input int pos, input int len);
    int e = 0;
    for (int i = 0; i < len; i++) e = (e << 1) | int'(RESP[63 - ((pos + i) % 64)]);
    return e;
  endfunction

  task automatic waitIdle();
    int guard = 0;
    @(negedge clk);
    while (busy && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic runWord(input logic [15:0] data, input int lenM1, input bit hold,
                         input int h, input bit tryOverwrite);
    int len = lenM1 + 1;
    int effH = (h == 0) ? 1 : h;
    int mask = (1 << len) - 1;
    @(negedge clk);
    divHalf = DIV_W'(h);
    rises = 0; capt = '0; hiCyc = 0; leadCyc = 0;
    wrEn = 1'b1; wrData = data; wrLen = 4'(lenM1); wrHold = hold;
    @(negedge clk);
    wrEn = 1'b0;
    check("R8 busy after write", int'(busy), 1);
    if (tryOverwrite) begin
      @(negedge clk);
      wrEn = 1'b1; wrData = ~data; wrLen = 4'd15; wrHold = ~hold;
      @(negedge clk);
      wrEn = 1'b0;
    end
    waitIdle();
    check("R2 pulse count", rises, len);
    check("R2 mosi bits", int'(capt) & mask, int'(data) & mask);
    if (hold) check("R4 cs held low", int'(csN), 0);
    else      check("R3 cs released", int'(csN), 1);
    check("R9 high cycles", hiCyc, effH * len);
    check("R10 setup cycles", leadCyc, effH);
    check("R7 ready set", int'(rxReady), 1);
    check("R6 R7 rx value", int'(rxData), expRx(predPos, len));
    predPos = hold ? predPos + len : 0;
    rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    check("R7 ready cleared", int'(rxReady), 0);
    if (tryOverwrite) begin
      repeat (4 * effH + 4) @(negedge clk);
      check("R8 ignored write no transfer", int'(busy), 0);
      check("R8 ignored write no pulses", rises, len);
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check("R1 csN", int'(csN), 1);
    check("R1 sclk", int'(sclk), 0);
    check("R1 busy", int'(busy), 0);
    check("R1 rxReady", int'(rxReady), 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    check("R5 no clocks before write", rises, 0);

    // Directed corners: length 16, length 1, zero divider.
    runWord(16'hC3A5, 15, 1'b0, 2, 1'b0);
    runWord(16'h0001, 0, 1'b0, 1, 1'b0);
    runWord(16'h8000, 0, 1'b0, 3, 1'b0);
    runWord(16'h5A3C, 7, 1'b0, 0, 1'b0);
    // 40-bit frame: opcode/address held, data word releases.
    runWord(16'h0203, 15, 1'b1, 1, 1'b0);
    runWord(16'hABCD, 15, 1'b1, 1, 1'b0);
    runWord(16'h00EE, 7, 1'b0, 1, 1'b0);
    // Write while busy.
    runWord(16'h1234, 11, 1'b0, 2, 1'b1);
    // Idle without writes.
    rises = 0;
    repeat (30) @(negedge clk);
    check("R5 no clocks while idle", rises, 0);
    check("R5 sclk idle low", int'(sclk), 0);
    check("R3 cs high idle", int'(csN), 1);

    // Random words; the last one always releases.
    for (int k = 0; k < 40; k++) begin
      logic [15:0] d = 16'($urandom());
      int lm = int'($urandom_range(15, 0));
      bit hd = (k == 39) ? 1'b0 : 1'($urandom_range(1, 0));
      int hh = int'($urandom_range(3, 0));
      runWord(d, lm, hd, hh, (k % 10) == 5);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    errors = errors + 1;
    checks = checks + 1;
    $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule